// File: doc/BRIEF.md
# Two-Hit Pixel Time-Stamp Front-End

This block is the digital logic that sits inside one pixel of a binary-readout sensor. It receives the asynchronous output of the pixel's discriminator and a time-stamp count that is shared across the array. It can keep two separate hits, and each hit keeps its own frozen copy of the count. Operation has two phases, selected by the `detect` input. While `detect` is high (the bunch train), the block records hits. While `detect` is low (the gap between trains), it offers its stored hits to a sparsified readout chain.

Each slot register copies the shared count on every clock until its hit flag is set. From then on it holds the count of that hit. The first hit uses slot one and the second hit uses slot two. Any further hit is dropped. During readout the pixel raises `hit_pending` and shows one stored hit on `ts_out`, with `hit_sel` naming the slot. Slot one is always shown before slot two. Each acknowledge clears the hit that is being shown. A cleared slot starts to follow the count again only when the next detection phase begins.

A kill bit silences a noisy pixel. While it is set, the pixel records nothing and requests nothing.

Top module: `pixel_dualhit_fe`

## Requirements
- R1: Hits are recorded only while `detect` is 1. `hit_pending` is 0 whenever `detect` is 1.
- R2: On the first hit, slot one stores the `ts_bus` value present at the capture edge. During readout that value appears on `ts_out` with `hit_sel`=0.
- R3: A second hit sets a separate flag and stores its own count in slot two. During readout, slot two is shown with `hit_sel`=1, but only after slot one has been acknowledged.
- R4: Once both slots hold hits, any further hit is dropped until readout clears a slot.
- R5: `disc_in` passes through a two-stage synchronizer and a rising-edge detector. A pulse that stays high for any number of cycles, with a minimum of one, produces exactly one hit.
- R6: While `kill` is 1, no hit is recorded and `hit_pending` stays 0.
- R7: When `read_ack` is 1 while `hit_pending` is 1, the hit being shown is cleared at that clock edge. A `read_ack` given during detection, or while nothing is pending, has no effect.
- R8: An active-low reset clears both hit flags and both slot registers.
- R9: While a slot's flag is clear in the detection phase, that slot follows `ts_bus` on every clock. After readout has cleared a slot, the slot captures a fresh count in the next detection phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| detect | input | 1 | 1 = detection phase, 0 = readout phase |
| disc_in | input | 1 | Asynchronous discriminator output |
| ts_bus | input | TSW | Shared time-stamp count |
| kill | input | 1 | Mask bit that disables the pixel |
| read_ack | input | 1 | Readout acknowledge for the hit being shown |
| hit_pending | output | 1 | A stored hit is waiting to be read |
| hit_sel | output | 1 | Slot being shown: 0 = first hit, 1 = second hit |
| ts_out | output | TSW | Time stamp of the hit being shown |

## Verification
Some properties are checked by assertions on every cycle:
- no request is made during detection or while the pixel is killed;
- a full pair of slots is never disturbed except by a real acknowledge;
- once slot one has been read, only slot two or nothing can follow;
- the shown stamp stays still while readout waits.

Other behaviour only the bench scenarios can show:
- that the stored values equal the counts present when the hits arrived;
- that a long discriminator pulse counts once;
- that hits arriving during readout or while killed leave no trace;
- that a reset or a fresh detection phase lets new counts be captured.

// File: rtl/pixel_dualhit_fe.sv
module pixel_dualhit_fe #(
  parameter int TSW  = 5,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           detect,
  input  logic           disc_in,
  input  logic [TSW-1:0] ts_bus,
  input  logic           kill,
  input  logic           read_ack,
  output logic           hit_pending,
  output logic           hit_sel,
  output logic [TSW-1:0] ts_out
);

  logic [SYNC:0]  sh;
  logic           f1, f2;
  logic [TSW-1:0] ts1, ts2;

  wire rise = sh[SYNC-1] & ~sh[SYNC];
  wire cap  = rise & detect & ~kill;
  wire take = read_ack & hit_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      f1  <= 1'b0;
      f2  <= 1'b0;
      ts1 <= '0;
      ts2 <= '0;
    end else begin
      sh <= {sh[SYNC-1:0], disc_in};
      if (detect) begin
        if (cap && !f1)      f1 <= 1'b1;
        else if (cap && !f2) f2 <= 1'b1;
        if (!f1) ts1 <= ts_bus;
        if (!f2) ts2 <= ts_bus;
      end else if (take) begin
        if (f1) f1 <= 1'b0;
        else    f2 <= 1'b0;
      end
    end
  end

  assign hit_pending = ~detect & ~kill & (f1 | f2);
  assign hit_sel     = ~f1;
  assign ts_out      = f1 ? ts1 : ts2;

endmodule

module pixel_dualhit_fe_chk #(
  parameter int TSW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           detect,
  input logic           kill,
  input logic           read_ack,
  input logic           hit_pending,
  input logic           hit_sel,
  input logic [TSW-1:0] ts_out,
  input logic           f1,
  input logic           f2
);

  a_r1_quiet_in_detect: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> !hit_pending);

  a_r6_kill_silent: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !hit_pending);

  a_r4_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 && f2 && !(read_ack && hit_pending)) |=> (f1 && f2));

  a_r3_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (read_ack && hit_pending && !hit_sel) |=> (!hit_pending || hit_sel));

  a_r7_last_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (read_ack && hit_pending && hit_sel) |=> !hit_pending);

  a_r2_stamp_still: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pending && !read_ack) |=> (!hit_pending || $stable(ts_out)));

endmodule

bind pixel_dualhit_fe pixel_dualhit_fe_chk #(.TSW(TSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .detect(detect), .kill(kill),
  .read_ack(read_ack), .hit_pending(hit_pending), .hit_sel(hit_sel),
  .ts_out(ts_out), .f1(f1), .f2(f2)
);

// File: tb/pixel_dualhit_fe_bench.sv
module pixel_dualhit_fe_bench;
  localparam int TSW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic detect = 1'b1;
  logic disc_in = 1'b0;
  logic [TSW-1:0] ts_bus = '0;
  logic kill = 1'b0;
  logic read_ack = 1'b0;
  logic hit_pending, hit_sel;
  logic [TSW-1:0] ts_out;

  int checks = 0;
  int errors = 0;
  logic [TSW:0] exp_q[$];

  always #4 clk = ~clk;

  pixel_dualhit_fe #(.TSW(TSW), .SYNC(2)) u_pixel_dualhit_fe (
    .clk(clk), .rst_n(rst_n), .detect(detect), .disc_in(disc_in),
    .ts_bus(ts_bus), .kill(kill), .read_ack(read_ack),
    .hit_pending(hit_pending), .hit_sel(hit_sel), .ts_out(ts_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hit(input logic [TSW-1:0] ts, input int len, input bit stored, input bit sel);
    ts_bus = ts;
    disc_in = 1'b1;
    repeat (len) @(negedge clk);
    disc_in = 1'b0;
    repeat (4) @(negedge clk);
    if (stored) exp_q.push_back({sel, ts});
    ts_bus = ts + 5'd13;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_all(input string req);
    logic [TSW:0] e;
    detect = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 8 && hit_pending; n++) begin
      if (exp_q.size() == 0) begin
        check(1'b0, req, {hit_sel, ts_out}, -1);
      end else begin
        e = exp_q.pop_front();
        check({hit_sel, ts_out} == e, req, {hit_sel, ts_out}, e);
      end
      read_ack = 1'b1;
      @(negedge clk);
      read_ack = 1'b0;
      @(negedge clk);
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(hit_pending == 1'b0, req, hit_pending, 0);
    exp_q.delete();
    detect = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: the reset state
    detect = 1'b0;
    @(negedge clk);
    check(hit_pending == 1'b0, "R8 reset", hit_pending, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(hit_pending == 1'b0, "R8 after reset", hit_pending, 0);
    detect = 1'b1;
    @(negedge clk);

    // R2: a single hit
    hit(5'd5, 1, 1, 0);
    check(hit_pending == 1'b0, "R1 no request in detect", hit_pending, 0);
    read_all("R2 single hit");

    // R3: two hits; R9: the slots were re-armed after readout
    hit(5'd9, 2, 1, 0);
    hit(5'd17, 1, 1, 1);
    read_all("R3 two hits R9");

    // R4: a third hit is dropped
    hit(5'd3, 1, 1, 0);
    hit(5'd4, 1, 1, 1);
    hit(5'd30, 1, 0, 0);
    read_all("R4 third dropped");

    // R5: a long pulse gives one hit
    hit(5'd21, 12, 1, 0);
    read_all("R5 long pulse");

    // R6: hits while killed are not recorded
    kill = 1'b1;
    hit(5'd11, 1, 0, 0);
    kill = 1'b0;
    read_all("R6 kill capture");

    // R6: a killed pixel makes no request, then shows its hit once unmasked
    hit(5'd14, 1, 0, 0);
    kill = 1'b1;
    detect = 1'b0;
    repeat (2) @(negedge clk);
    check(hit_pending == 1'b0, "R6 kill request", hit_pending, 0);
    kill = 1'b0;
    exp_q.push_back({1'b0, 5'd14});
    read_all("R6 unmasked");

    // R1: a hit during readout is ignored
    detect = 1'b0;
    @(negedge clk);
    hit(5'd7, 1, 0, 0);
    check(hit_pending == 1'b0, "R1 readout hit", hit_pending, 0);
    detect = 1'b1;
    repeat (2) @(negedge clk);
    read_all("R1 readout hit");

    // R7: an ack given during detection has no effect
    hit(5'd25, 1, 1, 0);
    hit(5'd26, 1, 1, 1);
    read_ack = 1'b1;
    repeat (2) @(negedge clk);
    read_ack = 1'b0;
    read_all("R7 ack in detect");

    // R8: reset clears stored hits
    hit(5'd19, 1, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R8 reset clears");

    // R9: a fresh count is captured after the reset
    hit(5'd31, 1, 1, 0);
    read_all("R9 fresh count");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule